// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit wide first-in first-out buffer whose write side and read side each run on their own free-running clock. The two clocks may be unrelated or may be the same net. A producer presents a word and raises the write enable, and a consumer raises the read enable. Read data comes from a register and is driven onto the output only while the output enable is high. Otherwise the output floats.

Five status outputs describe the fill level: empty, almost empty, half full, almost full and full. The almost-empty and almost-full thresholds are offsets held in registers. Both come out of reset at 127 and can be reloaded from the write-clock side. A retransmit strobe moves the read position back to storage location zero, so that data already read can be replayed. Pointers cross between the clock domains as Gray codes. Empty and almost empty are computed in the read domain. Full, half full and almost full are computed in the write domain.

Top module: `dual_clk_fifo`

## Requirements
- R1: Words leave the read port in exactly the order they were accepted at the write port, with all 18 bits intact.
- R2: With no words stored, empty is 1. The word returned by an accepted read (read enable high while empty is 0 at a read-clock edge) is on the read data output from that edge until the next accepted read.
- R3: Full is 1 exactly when DEPTH words are stored. A write attempted while full is 1 is discarded and does not change the stored contents.
- R4: A read attempted while empty is 1 is ignored: the read data output keeps its value and no word is consumed.
- R5: Almost empty is 1 when the read side sees a count of stored words less than or equal to the empty offset, and 0 otherwise.
- R6: Almost full is 1 when the write side sees a count of at least DEPTH minus the full offset, and 0 otherwise.
- R7: Half full is 1 when at least DEPTH/2+1 words are stored, and 0 when DEPTH/2 or fewer are stored.
- R8: Both offsets are 127 after reset. A write-clock edge with the offset load input high loads the two offset inputs into the offsets.
- R9: A retransmit pulse (rt high for one read-clock edge, with no read in that cycle) sets the read position to location 0. The following reads return the words in their original order again, until the read position meets the write position.
- R10: While the output enable is 0, the read data output is high impedance on every bit.
- R11: Reset (rst_n low) clears both pointers and the read data register. After it, empty and almost empty are 1, and full, half full and almost full are 0.
- R12: R1 to R7 hold both when the read clock is the write clock and when the two clocks are unrelated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write request |
| wdata | input | 18 | Write data |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit strobe, read-clock domain |
| oe | input | 1 | Output enable for q |
| ofs_load | input | 1 | Load strobe for both offsets, write-clock domain |
| ofs_ae | input | $clog2(DEPTH) | New almost-empty offset |
| ofs_af | input | $clog2(DEPTH) | New almost-full offset |
| q | output | 18 | Read data, high impedance while oe is 0 |
| empty | output | 1 | No words stored (read domain) |
| aempty | output | 1 | Count at or below the empty offset (read domain) |
| half | output | 1 | At least DEPTH/2+1 words stored (write domain) |
| afull | output | 1 | Count at or above DEPTH minus the full offset (write domain) |
| full | output | 1 | DEPTH words stored (write domain) |

## Verification
The assertions assume that retransmit is never raised together with a read. They also assume it is raised only when fewer than DEPTH words have been written since reset and the write side is idle. The offsets are assumed to change only while both ports are idle. The bench honours all three assumptions. It drives retransmit and offset loads only in directed phases, after a reset and with a settling gap on both clocks, and it never writes past DEPTH words before a rewind. The random phases vary only the two enables and the data, under tied clocks and again under unrelated clocks.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  parameter int unsigned WORD_W  = 18;
  parameter int unsigned OFS_DEF = 127;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  logic [W-1:0] meta_n;
  logic [W-1:0] stab;
  logic [W-1:0] stab_n;

  always_comb begin
    meta_n = d;
    stab_n = meta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      stab <= '0;
    end else begin
      meta <= meta_n;
      stab <= stab_n;
    end
  end

  assign q = stab;
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned OFS_DEF = 127,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          ofs_load,
  input  logic [AW-1:0] ofs_ae_in,
  input  logic [AW-1:0] ofs_af_in,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic          wr_ok,
  output logic          full,
  output logic          afull,
  output logic          half,
  output logic [AW-1:0] ae_ofs
);
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] wcnt;
  logic [PW-1:0] wptr_n;
  logic [PW-1:0] wgray_n;
  logic [AW-1:0] ae_q, ae_n;
  logic [AW-1:0] af_q, af_n;

  // Gray to binary for the synchronised read pointer
  for (genvar i = 0; i < PW; i++) begin : g_r2b
    assign rbin_s[i] = ^rgray_s[PW-1:i];
  end

  always_comb begin
    wcnt    = wptr - rbin_s;
    full    = (wcnt == PW'(DEPTH));
    half    = (wcnt >= PW'(DEPTH / 2 + 1));
    afull   = (wcnt >= (PW'(DEPTH) - {1'b0, af_q}));
    wr_ok   = wr_en & ~full;
    wptr_n  = wptr + {{AW{1'b0}}, wr_ok};
    wgray_n = wptr_n ^ (wptr_n >> 1);
    ae_n    = ofs_load ? ofs_ae_in : ae_q;
    af_n    = ofs_load ? ofs_af_in : af_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      ae_q  <= AW'(OFS_DEF);
      af_q  <= AW'(OFS_DEF);
    end else begin
      wptr  <= wptr_n;
      wgray <= wgray_n;
      ae_q  <= ae_n;
      af_q  <= af_n;
    end
  end

  assign ae_ofs = ae_q;
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rt,
  input  logic [PW-1:0] wgray_s,
  input  logic [AW-1:0] ae_ofs,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic          rd_ok,
  output logic          empty,
  output logic          aempty
);
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] rcnt;
  logic [PW-1:0] rptr_n;
  logic [PW-1:0] rgray_n;

  for (genvar i = 0; i < PW; i++) begin : g_w2b
    assign wbin_s[i] = ^wgray_s[PW-1:i];
  end

  always_comb begin
    rcnt    = wbin_s - rptr;
    empty   = (rgray == wgray_s);
    aempty  = (rcnt <= {1'b0, ae_ofs});
    rd_ok   = rd_en & ~empty & ~rt;
    if (rt) begin
      rptr_n = '0;
    end else begin
      rptr_n = rptr + {{AW{1'b0}}, rd_ok};
    end
    rgray_n = rptr_n ^ (rptr_n >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else begin
      rptr  <= rptr_n;
      rgray <= rgray_n;
    end
  end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem
  import fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t store [DEPTH];
  word_t rdata_q;
  word_t rdata_n;

  always_ff @(posedge wclk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_n = re ? store[raddr] : rdata_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_n;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
  import fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [17:0]   wdata,
  input  logic          rd_en,
  input  logic          rt,
  input  logic          oe,
  input  logic          ofs_load,
  input  logic [AW-1:0] ofs_ae,
  input  logic [AW-1:0] ofs_af,
  output logic [17:0]   q,
  output logic          empty,
  output logic          aempty,
  output logic          half,
  output logic          afull,
  output logic          full
);
  logic          wrst_s;
  logic          rrst_s;
  logic [PW-1:0] wptr, wgray, wgray_s;
  logic [PW-1:0] rptr, rgray, rgray_s;
  logic          wr_ok, rd_ok;
  logic [AW-1:0] ae_ofs;
  word_t         rdata;

  // Per-domain reset: asserted asynchronously, released on the local clock
  fifo_sync2 #(.W(1)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_s));
  fifo_sync2 #(.W(1)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_s));

  // Gray pointer crossings
  fifo_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_s), .d(wgray), .q(wgray_s));
  fifo_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_s), .d(rgray), .q(rgray_s));

  fifo_wr_ctl #(.DEPTH(DEPTH), .OFS_DEF(OFS_DEF)) u_wr (
    .clk(wclk), .rst_n(wrst_s), .wr_en(wr_en),
    .ofs_load(ofs_load), .ofs_ae_in(ofs_ae), .ofs_af_in(ofs_af),
    .rgray_s(rgray_s), .wptr(wptr), .wgray(wgray), .wr_ok(wr_ok),
    .full(full), .afull(afull), .half(half), .ae_ofs(ae_ofs)
  );

  // ae_ofs is quasi-static: changed only while both ports are idle
  fifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk(rclk), .rst_n(rrst_s), .rd_en(rd_en), .rt(rt),
    .wgray_s(wgray_s), .ae_ofs(ae_ofs), .rptr(rptr), .rgray(rgray),
    .rd_ok(rd_ok), .empty(empty), .aempty(aempty)
  );

  fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(wr_ok), .waddr(wptr[AW-1:0]), .wdata(wdata),
    .rclk(rclk), .rrst_n(rrst_s), .re(rd_ok), .raddr(rptr[AW-1:0]),
    .rdata(rdata)
  );

  assign q = oe ? rdata : 'z;
endmodule

// File: rtl/fifo_chk.sv
module fifo_chk #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          rt,
  input logic          full,
  input logic          empty,
  input logic          aempty,
  input logic          afull,
  input logic          half,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [17:0]   rdata
);
  assert_ptr_step_R1: assert property (@(posedge wclk) disable iff (!wrst_n)
    ((wptr - $past(wptr)) <= PW'(1)));

  assert_full_hold_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |=> (wptr == $past(wptr)));

  assert_empty_hold_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && !rt) |=> ((rptr == $past(rptr)) && $stable(rdata)));

  assert_empty_ae_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> aempty);

  assert_full_flags_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> (afull && half));

  assert_rewind_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    rt |=> (rptr == '0));
endmodule

bind dual_clk_fifo fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_s), .rrst_n(rrst_s), .rt(rt),
  .full(full), .empty(empty), .aempty(aempty), .afull(afull), .half(half),
  .wptr(wptr), .rptr(rptr), .rdata(rdata)
);

// File: tb/tb_dual_clk_fifo.sv
module tb_dual_clk_fifo;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH       = 256;
  localparam int AW          = $clog2(DEPTH);
  localparam int WDOG        = 190000;

  logic wclk = 1'b0;
  logic rclk_free = 1'b0;
  logic tied = 1'b1;
  logic rclk;
  logic rst_n, wr_en, rd_en, rt, oe, ofs_load;
  logic [17:0] wdata;
  logic [AW-1:0] ofs_ae, ofs_af;
  wire  [17:0] q;
  logic empty, aempty, half, afull, full;

  int checks = 0;
  int errors = 0;
  logic [17:0] hist[$];
  int rd_idx = 0;
  int ae_n = 127;
  int af_m = 127;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk_free = ~rclk_free;
  always_comb rclk = tied ? wclk : rclk_free;

  dual_clk_fifo #(.DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rt(rt), .oe(oe), .ofs_load(ofs_load), .ofs_ae(ofs_ae),
    .ofs_af(ofs_af), .q(q), .empty(empty), .aempty(aempty), .half(half),
    .afull(afull), .full(full)
  );

  function automatic int occ();
    return hist.size() - rd_idx;
  endfunction

  task automatic check_eq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rt = 1'b0; oe = 1'b1;
    ofs_load = 1'b0; ofs_ae = '0; ofs_af = '0; wdata = '0;
    repeat (3) @(negedge wclk);
    repeat (3) @(negedge rclk);
    rst_n = 1'b1;
    hist.delete(); rd_idx = 0; ae_n = 127; af_m = 127;
    settle();
  endtask

  task automatic check_flags(string tag);
    int n = occ();
    check_eq("R2", {tag, " empty"}, longint'(empty), longint'(n == 0));
    check_eq("R3", {tag, " full"}, longint'(full), longint'(n == DEPTH));
    check_eq("R5", {tag, " aempty"}, longint'(aempty), longint'(n <= ae_n));
    check_eq("R6", {tag, " afull"}, longint'(afull), longint'(n >= DEPTH - af_m));
    check_eq("R7", {tag, " half"}, longint'(half), longint'(n >= DEPTH/2 + 1));
  endtask

  task automatic wr1(logic [17:0] d);
    @(negedge wclk);
    if (!full) hist.push_back(d);
    wr_en = 1'b1; wdata = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd1(string req);
    logic ok;
    logic [17:0] prev;
    @(negedge rclk);
    ok = !empty; prev = q;
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    if (ok) begin
      check_eq(req, "read data", longint'(q), longint'(hist[rd_idx]));
      rd_idx++;
    end else begin
      check_eq("R4", "q held on empty read", longint'(q), longint'(prev));
    end
  endtask

  task automatic drain(string req);
    while (occ() > 0) rd1(req);
    settle();
    check_flags({req, " drained"});
  endtask

  task automatic random_phase(int nw, int nr, int wpct, int rpct);
    fork
      begin
        for (int i = 0; i < nw; i++) begin
          @(negedge wclk);
          wr_en = (($urandom % 100) < wpct);
          wdata = 18'($urandom);
          if (wr_en && !full) hist.push_back(wdata);
        end
        @(negedge wclk);
        wr_en = 1'b0;
      end
      begin
        logic pend = 1'b0;
        logic [17:0] exp = '0;
        for (int i = 0; i < nr; i++) begin
          @(negedge rclk);
          if (pend) check_eq("R12", "random read data", longint'(q), longint'(exp));
          pend = 1'b0;
          rd_en = (($urandom % 100) < rpct);
          if (rd_en && !empty) begin
            exp = hist[rd_idx]; rd_idx++; pend = 1'b1;
          end
        end
        @(negedge rclk);
        if (pend) check_eq("R12", "random read data", longint'(q), longint'(exp));
        rd_en = 1'b0;
      end
    join
    settle();
    check_flags("R12 after random");
  endtask

  initial begin
    repeat (WDOG) @(posedge wclk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    tied = 1'b1;
    reset_dut();

    // R11 reset state
    check_eq("R11", "empty", longint'(empty), 1);
    check_eq("R11", "aempty", longint'(aempty), 1);
    check_eq("R11", "full", longint'(full), 0);
    check_eq("R11", "half", longint'(half), 0);
    check_eq("R11", "afull", longint'(afull), 0);
    check_eq("R11", "q", longint'(q), 0);

    // R10 output enable
    oe = 1'b0;
    #1;
    checks++;
    if (q !== 18'bz) begin
      errors++;
      $display("FAIL R10 q not high-z actual=%0h expected=zzzzz", q);
    end
    oe = 1'b1;

    // R4 read while empty
    rd1("R4");

    // R2 first word
    wr1(18'h2a5a5);
    settle();
    check_flags("R2 one word");
    rd1("R2");
    settle();
    check_flags("R2 after read");

    // R3/R5/R6/R7 fill boundaries with default offsets (R8 reset value)
    for (int i = 0; i < DEPTH; i++) begin
      wr1(18'(i * 37 + 5));
      if (occ() inside {127, 128, 129, 255, 256}) begin
        settle();
        check_flags("R8 default offsets fill");
      end
    end
    wr1(18'h3ffff);
    settle();
    check_flags("R3 write while full");
    drain("R3");

    // R9 retransmit
    reset_dut();
    for (int i = 0; i < 20; i++) wr1(18'(i + 100));
    settle();
    for (int i = 0; i < 20; i++) rd1("R1");
    settle();
    @(negedge rclk); rt = 1'b1;
    @(negedge rclk); rt = 1'b0;
    rd_idx = 0;
    settle();
    check_flags("R9 after rewind");
    drain("R9");

    // R8 loaded offsets
    reset_dut();
    @(negedge wclk);
    ofs_load = 1'b1; ofs_ae = AW'(10); ofs_af = AW'(20);
    @(negedge wclk);
    ofs_load = 1'b0;
    ae_n = 10; af_m = 20;
    settle();
    for (int i = 0; i < 237; i++) begin
      wr1(18'($urandom));
      if (occ() inside {10, 11, 235, 236}) begin
        settle();
        check_flags("R8 loaded offsets");
      end
    end
    drain("R8");

    // R12 tied clocks
    reset_dut();
    random_phase(3000, 3000, 75, 35);
    random_phase(2000, 2000, 35, 75);
    drain("R12");

    // R12 unrelated clocks
    tied = 1'b0;
    reset_dut();
    random_phase(3000, 2200, 75, 40);
    random_phase(1500, 2200, 30, 80);
    drain("R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule